// File: doc/BRIEF.md
# Multi-Channel Serial DAC Loader

This block drives a group of serial digital-to-analog converters, one converter per channel. Every channel owns a 16-bit holding register and a dedicated serializer. Writing a channel's register launches a transfer on that channel with no other command. During the transfer the channel drives its active-low select, its serial clock and its data line. Only the twelve right-justified significant bits go out, most significant first. After the select is released, the channel gives one parallel-load pulse so that the converter moves the new code into its output latch.

Channels run independently, so transfers on different channels can overlap in any pattern. A write to a channel that is already busy updates the holding register. The newest value is then shifted out as soon as the running transfer, including its load pulse, has finished. The serial clock period is `CLK_DIV` system clocks, default 4. A complete transfer takes 14 serial periods: twelve bit periods, one trailing select period and one load period.

Top module: `dac_group_loader`

## Requirements
- R1: After reset every channel idles with `sel_n` high, `sclk` low, `sdata` low, `load` low and `busy` low. An idle channel keeps these values until it is written.
- R2: A write (`wr_en` high, `wr_chan` = channel index) raises that channel's `busy` in the cycle after the write edge, and pulls its `sel_n` low one cycle after that.
- R3: In bit period k (k = 0..11) a channel's `sdata` carries bit 11-k of the written word. Bits 15:12 are never sent, and `sdata` is low outside bit periods.
- R4: In each bit period `sclk` is low for the first `CLK_DIV`/2 system cycles and high for the rest. `sdata` changes only while `sclk` is low, and `sclk` stays low outside bit periods.
- R5: `sel_n` stays low through the twelve bit periods plus one further serial period, and then returns high.
- R6: `load` is high for exactly one serial period, starting in the cycle in which `sel_n` returns high, and is low at all other times.
- R7: A write to a busy channel replaces its held value. That value is transferred right after the running load period ends, with no idle cycle between, and earlier values written in the meantime are dropped.
- R8: Writes to different channels start transfers that proceed concurrently, and each transfer is unaffected by the others.
- R9: `busy` is high from the cycle after the write until the last cycle of the final load period, and never while the channel is idle with nothing held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | $clog2(NCH) | Channel index of the write |
| wr_data | input | DW | Write data, right-justified, 12 significant bits |
| sel_n | output | NCH | Per-channel active-low converter select |
| sclk | output | NCH | Per-channel serial clock |
| sdata | output | NCH | Per-channel serial data |
| load | output | NCH | Per-channel active-high parallel-load strobe |
| busy | output | NCH | Per-channel transfer or pending-write flag |

## Verification
A corrupted bit counter or shift register shows up at the ports within one serial period. The `sdata` level is then wrong at a rising `sclk`, or the select window grows or shrinks by whole periods and moves the `load` pulse. A lost pending flag shows as `busy` falling, and `sel_n` staying high, in the cycle after the load period ends, where a back-to-back transfer was due. A decode fault on the channel index shows on the wrong channel's `busy` one cycle after the write. The reference model compares every output of every channel on every clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_SHIFT = 2'd1,
    CH_TAIL  = 2'd2,
    CH_LOAD  = 2'd3
  } ch_state_e;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dac_chan_ser.sv
module dac_chan_ser
  import dac_loader_pkg::*;
#(
  parameter int NBITS   = 12,
  parameter int CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NBITS-1:0] wr_word,
  output logic             sel_n,
  output logic             sclk,
  output logic             sdata,
  output logic             load,
  output logic             busy
);
  localparam int CW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BW   = $clog2(NBITS);
  localparam int HALF = CLK_DIV / 2;

  ch_state_e        st_q, st_d;
  logic [CW-1:0]    cyc_q, cyc_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic [NBITS-1:0] sh_q, sh_d;
  logic [NBITS-1:0] hold_q, hold_d;
  logic             pend_q, pend_d;
  logic             period_end;
  logic [CW-1:0]    cyc_inc;
  logic             start;

  assign period_end = (cyc_q == CW'(CLK_DIV - 1));
  assign cyc_inc    = period_end ? '0 : cyc_q + 1'b1;

  always_comb begin
    st_d   = st_q;
    cyc_d  = cyc_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    hold_d = hold_q;
    pend_d = pend_q;
    start  = 1'b0;
    unique case (st_q)
      CH_IDLE: begin
        if (pend_q) start = 1'b1;
      end
      CH_SHIFT: begin
        cyc_d = cyc_inc;
        if (period_end) begin
          if (bit_q == BW'(NBITS - 1)) begin
            st_d = CH_TAIL;
          end else begin
            bit_d = bit_q + 1'b1;
            sh_d  = {sh_q[NBITS-2:0], 1'b0};
          end
        end
      end
      CH_TAIL: begin
        cyc_d = cyc_inc;
        if (period_end) st_d = CH_LOAD;
      end
      CH_LOAD: begin
        cyc_d = cyc_inc;
        if (period_end) begin
          if (pend_q) start = 1'b1;
          else        st_d  = CH_IDLE;
        end
      end
      default: st_d = CH_IDLE;
    endcase
    if (start) begin
      st_d   = CH_SHIFT;
      cyc_d  = '0;
      bit_d  = '0;
      sh_d   = hold_q;
      pend_d = 1'b0;
    end
    if (wr_en) begin
      hold_d = wr_word;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      cyc_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cyc_q  <= cyc_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  assign sel_n = !((st_q == CH_SHIFT) || (st_q == CH_TAIL));
  assign sclk  = (st_q == CH_SHIFT) && (cyc_q >= CW'(HALF));
  assign sdata = (st_q == CH_SHIFT) && sh_q[NBITS-1];
  assign load  = (st_q == CH_LOAD);
  assign busy  = pend_q || (st_q != CH_IDLE);
endmodule

// File: rtl/dac_group_loader.sv
module dac_group_loader #(
  parameter int NCH     = 4,
  parameter int DW      = 16,
  parameter int NBITS   = 12,
  parameter int CLK_DIV = 4,
  localparam int CHW    = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_chan,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] sel_n,
  output logic [NCH-1:0] sclk,
  output logic [NCH-1:0] sdata,
  output logic [NCH-1:0] load,
  output logic [NCH-1:0] busy
);
  logic rst_n_int;
  logic unused_hi;

  assign unused_hi = ^wr_data[DW-1:NBITS];

  dac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en && (wr_chan == CHW'(c));

    dac_chan_ser #(.NBITS(NBITS), .CLK_DIV(CLK_DIV)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .wr_en   (ch_wr),
      .wr_word (wr_data[NBITS-1:0]),
      .sel_n   (sel_n[c]),
      .sclk    (sclk[c]),
      .sdata   (sdata[c]),
      .load    (load[c]),
      .busy    (busy[c])
    );
  end
endmodule

// File: rtl/dac_group_loader_chk.sv
module dac_group_loader_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] sel_n,
  input logic [NCH-1:0] sclk,
  input logic [NCH-1:0] sdata,
  input logic [NCH-1:0] load,
  input logic [NCH-1:0] busy
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[c] |-> (sel_n[c] && !sclk[c] && !sdata[c] && !load[c]));
    // R4
    clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk[c] |-> !sel_n[c]);
    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk[c] && $past(sclk[c])) |-> $stable(sdata[c]));
    // R6
    load_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load[c] |-> sel_n[c]);
    // R6
    load_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load[c]) |-> $rose(sel_n[c]));
    // R9
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load[c] |-> busy[c]);
  end
endmodule

bind dac_group_loader dac_group_loader_chk #(.NCH(NCH)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sel_n (sel_n),
  .sclk  (sclk),
  .sdata (sdata),
  .load  (load),
  .busy  (busy)
);

// File: tb/tb_dac_group_loader.sv
module tb_dac_group_loader;
  localparam int NCH  = 4;
  localparam int P    = 4;
  localparam int NB   = 12;
  localparam int XFER = (NB + 2) * P;
  localparam int WDOG = 100000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_chan;
  logic [15:0] wr_data;
  logic [NCH-1:0] sel_n, sclk, sdata, load, busy;

  int compared;
  int mismatched;
  int cycles;
  bit finished;

  // behavioural reference state
  bit          m_act  [NCH];
  bit          m_pend [NCH];
  int          m_tick [NCH];
  logic [15:0] m_hold [NCH];
  logic [15:0] m_word [NCH];

  dac_group_loader dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_data(wr_data), .sel_n(sel_n), .sclk(sclk), .sdata(sdata),
    .load(load), .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        m_act[c] = 0; m_pend[c] = 0; m_tick[c] = 0; m_hold[c] = '0;
      end else begin
        bit was_pend;
        bit go;
        was_pend = m_pend[c];
        go = 0;
        if (m_act[c]) begin
          if (m_tick[c] == XFER - 1) begin
            if (was_pend) go = 1;
            else m_act[c] = 0;
          end else m_tick[c]++;
        end else if (was_pend) go = 1;
        if (go) begin
          m_act[c] = 1; m_tick[c] = 0; m_word[c] = m_hold[c]; m_pend[c] = 0;
        end
        if (wr_en && wr_chan == c[1:0]) begin
          m_hold[c] = wr_data; m_pend[c] = 1;
        end
      end
    end
  end

  task automatic cmp(input string req, input int c, input string nm,
                     input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s ch%0d %s at cycle %0d: got %b expected %b",
               req, c, nm, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        logic e_sel, e_clk, e_dat, e_ld, e_bsy;
        int t;
        t = m_tick[c];
        e_sel = 1; e_clk = 0; e_dat = 0; e_ld = 0;
        if (m_act[c]) begin
          if (t < NB * P) begin
            e_sel = 0;
            e_clk = ((t % P) >= P / 2);
            e_dat = m_word[c][NB - 1 - t / P];
          end else if (t < (NB + 1) * P) e_sel = 0;
          else e_ld = 1;
        end
        e_bsy = m_act[c] | m_pend[c];
        cmp("R5/R8", c, "sel_n", sel_n[c], e_sel);
        cmp("R4", c, "sclk", sclk[c], e_clk);
        cmp("R3/R7/R8", c, "sdata", sdata[c], e_dat);
        cmp("R6", c, "load", load[c], e_ld);
        cmp("R9", c, "busy", busy[c], e_bsy);
      end
    end
  end

  task automatic put(input int c, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_chan = c[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: run did not end, got %0d cycles expected < %0d",
               cycles, WDOG);
      summary();
      $finish;
    end
  end

  initial begin
    compared = 0; mismatched = 0; cycles = 0; finished = 0;
    wr_en = 0; wr_chan = '0; wr_data = '0;
    rst_n = 0;
    idle(3);
    // R1: outputs idle while reset is held
    cmp("R1", 0, "sel_n all", &sel_n, 1'b1);
    cmp("R1", 0, "sclk any", |sclk, 1'b0);
    cmp("R1", 0, "load any", |load, 1'b0);
    cmp("R1", 0, "busy any", |busy, 1'b0);
    @(posedge clk); #1 rst_n = 1;
    idle(5);

    // R2: busy one cycle after the write, select one cycle later
    @(negedge clk);
    wr_en = 1; wr_chan = 2'd0; wr_data = 16'h0A5C;
    @(negedge clk);
    wr_en = 0;
    cmp("R2", 0, "busy after write", busy[0], 1'b1);
    cmp("R2", 0, "sel_n before start", sel_n[0], 1'b1);
    @(negedge clk);
    cmp("R2", 0, "sel_n at start", sel_n[0], 1'b0);
    idle(XFER + 4);

    // R3: upper bits never sent
    put(2, 16'hF000);
    idle(XFER + 4);
    put(3, 16'hFFFF);
    idle(XFER + 4);

    // R8: overlapping transfers on several channels
    put(1, 16'h0FFF);
    idle(7);
    put(3, 16'h0123);
    idle(3);
    put(0, 16'h0800);
    put(2, 16'h0001);
    idle(XFER + 10);

    // R7: rewrites while busy, newest value follows back to back
    put(1, 16'h0111);
    idle(10);
    put(1, 16'h0222);
    idle(10);
    put(1, 16'h0333);
    idle(2 * XFER + 8);

    // R7: second write landing around the end of a load period
    for (int off = XFER - 4; off <= XFER + 2; off++) begin
      put(2, 16'h0C3A);
      idle(off - 1);
      put(2, 16'h035C ^ 16'(off));
      idle(2 * XFER + 6);
    end

    // R8: all channels written on consecutive cycles
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      wr_en = 1; wr_chan = c[1:0]; wr_data = 16'h0F0F ^ 16'(c * 16'h0111);
      @(negedge clk);
    end
    wr_en = 0;
    idle(XFER + 10);

    // R1: all channels idle again at the end
    cmp("R1", 0, "busy any at end", |busy, 1'b0);
    cmp("R1", 0, "sel_n all at end", &sel_n, 1'b1);

    finished = 1;
    summary();
    $finish;
  end
endmodule